// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 14-bit virtual address into a 14-bit physical address by walking a two-level table held in memory. The upper four address bits pick an entry in a page directory whose base is held in a register. That directory entry names the frame holding one 64-byte chunk of the page table. The next four address bits pick an entry inside that chunk, and its frame number is joined with the 6-bit page offset to form the result.

A chunk of the page table whose entries would all be invalid never has to exist. Its directory entry is simply marked invalid, and the walk stops there with a directory fault after a single read. The walker accepts one request at a time and issues at most two reads, directory entry first and table entry second, on a read port whose latency may vary. It answers with a one-cycle response that carries the physical address or a fault code.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_rd_req is 0 and the directory base register holds 0.
- R2: The first read of a walk uses address base + 4 * vaddr[13:10], truncated to 14 bits.
- R3: When the directory entry read back has bit 31 clear, the walk makes no further read and responds with rsp_fault = 2'b01 and rsp_paddr = 0.
- R4: When the directory entry has bit 31 set, the second read uses address (entry[7:0] << 6) + 4 * vaddr[9:6].
- R5: When the table entry has bit 31 clear, the response carries rsp_fault = 2'b10 and rsp_paddr = 0, after exactly two reads.
- R6: When both entries have bit 31 set, the response carries rsp_fault = 2'b00 and rsp_paddr = {table entry[7:0], vaddr[5:0]}.
- R7: rsp_valid is high for exactly one cycle per accepted request, and req_ready is 0 from the cycle after acceptance until the cycle after the response.
- R8: A base write affects only requests accepted in later cycles. A request accepted in the same cycle as the write uses the previous base, and a write during a walk leaves that walk's addresses unchanged.
- R9: mem_rd_valid is ignored while no read is outstanding.
- R10: A read request and its address stay stable until mem_rd_valid arrives, for any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 14 | New directory base byte address |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 14 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 14 | Translated physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 directory fault, 10 page fault |
| mem_rd_req | output | 1 | Read request, held until data returns |
| mem_rd_addr | output | 14 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Entry read from memory |

## Verification
A base register write and the acceptance of a request can fall in the same cycle. A write can also arrive while a walk is still waiting on memory. The bench provokes both by asserting the base write together with req_valid, or one cycle after acceptance, under a fixed-seed random mix. It judges the result by comparing the captured read addresses and the response with a model that holds the old base for that walk and uses the new base from the next request on.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W      = 14,
  parameter int OFF_W     = 6,
  parameter int DIR_W     = 4,
  parameter int FRM_W     = 8,
  parameter int ENT_W     = 32,
  parameter int VLD_BIT   = 31,
  parameter int ENT_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   base_we,
  input  logic [FRM_W+OFF_W-1:0] base_wdata,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [FRM_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]             rsp_fault,
  output logic                   mem_rd_req,
  output logic [FRM_W+OFF_W-1:0] mem_rd_addr,
  input  logic                   mem_rd_valid,
  input  logic [ENT_W-1:0]       mem_rd_data
);
  localparam int PA_W  = FRM_W + OFF_W;
  localparam int TIX_W = VA_W - OFF_W - DIR_W;
  localparam int LO_W  = VA_W - DIR_W;
  localparam int ESH   = $clog2(ENT_BYTES);
  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_DIR  = 2'd1;
  localparam logic [1:0] FLT_PAGE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_PDE, S_PTE, S_DONE} st_t;

  st_t              st;
  logic [PA_W-1:0]  base_q, addr_q, pa_q;
  logic [LO_W-1:0]  va_lo_q;
  logic [1:0]       flt_q;

  wire              accept  = req_valid && (st == S_IDLE);
  wire              got     = mem_rd_req && mem_rd_valid;
  wire              ent_ok  = mem_rd_data[VLD_BIT];
  wire [PA_W-1:0]   dir_off = PA_W'(req_vaddr[VA_W-1 -: DIR_W]) << ESH;
  wire [PA_W-1:0]   tbl_off = PA_W'(va_lo_q[OFF_W +: TIX_W]) << ESH;
  wire [PA_W-1:0]   pte_adr = {mem_rd_data[FRM_W-1:0], {OFF_W{1'b0}}} + tbl_off;

  logic unused_bits;
  assign unused_bits = ^mem_rd_data;

  assign req_ready   = (st == S_IDLE);
  assign mem_rd_req  = (st == S_PDE) || (st == S_PTE);
  assign mem_rd_addr = addr_q;
  assign rsp_valid   = (st == S_DONE);
  assign rsp_paddr   = pa_q;
  assign rsp_fault   = flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= base_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      pa_q    <= '0;
      va_lo_q <= '0;
      flt_q   <= FLT_NONE;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= S_PDE;
          addr_q  <= base_q + dir_off;
          va_lo_q <= req_vaddr[LO_W-1:0];
        end
        S_PDE: if (got) begin
          if (ent_ok) begin
            st     <= S_PTE;
            addr_q <= pte_adr;
          end else begin
            st    <= S_DONE;
            pa_q  <= '0;
            flt_q <= FLT_DIR;
          end
        end
        S_PTE: if (got) begin
          st <= S_DONE;
          if (ent_ok) begin
            pa_q  <= {mem_rd_data[FRM_W-1:0], va_lo_q[OFF_W-1:0]};
            flt_q <= FLT_NONE;
          end else begin
            pa_q  <= '0;
            flt_q <= FLT_PAGE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

  assert_pulse_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  assert_start_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_rd_req && !req_ready);

  assert_invalid_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_valid && !mem_rd_data[VLD_BIT] |=> rsp_valid && rsp_fault != FLT_NONE && rsp_paddr == '0);

  assert_fault_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'b11);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_req && !rsp_valid);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        base_we = 0;
  logic [13:0] base_wdata = '0;
  logic        req_valid = 0;
  logic [13:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, mem_rd_req;
  logic [13:0] rsp_paddr, mem_rd_addr;
  logic [1:0]  rsp_fault;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data = '0;
  logic        mrv = 0, stray = 0;

  logic [31:0] mem [4096];
  logic [13:0] rd_log [4];
  int          nreads = 0, wait_cnt = 0;
  int          total = 0, fails = 0, cyc = 0;
  logic [13:0] base_m = '0;

  assign mem_rd_valid = mrv | stray;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data));

  always @(negedge clk) begin
    if (mrv) mrv = 0;
    else if (mem_rd_req) begin
      if (wait_cnt == 0) begin
        mrv = 1;
        mem_rd_data = mem[mem_rd_addr[13:2]];
        if (nreads < 4) rd_log[nreads] = mem_rd_addr;
        nreads++;
        wait_cnt = $urandom_range(0, 3);
      end else wait_cnt--;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] pde_addr(input logic [13:0] b, input logic [13:0] va);
    return b + {8'd0, va[13:10], 2'b00};
  endfunction

  function automatic logic [13:0] pte_addr(input logic [31:0] d, input logic [13:0] va);
    return {d[7:0], 6'd0} + {8'd0, va[9:6], 2'b00};
  endfunction

  task automatic set_path(input logic [13:0] b, input logic [13:0] va, input bit pv, input bit qv);
    logic [13:0] a = pde_addr(b, va);
    logic [31:0] d = {pv, $urandom()} ;
    mem[a[13:2]] = d;
    a = pte_addr(d, va);
    mem[a[13:2]] = {qv, 31'($urandom())};
  endtask

  task automatic do_walk(input logic [13:0] va, input int mode, input logic [13:0] nb);
    logic [13:0] eb = base_m;
    logic [13:0] pa, pt, exp_pa;
    logic [31:0] d, e;
    logic [1:0]  exp_f;
    int          exp_n, guard;
    pa = pde_addr(eb, va);
    d  = mem[pa[13:2]];
    pt = pte_addr(d, va);
    e  = mem[pt[13:2]];
    if (!d[31])      begin exp_f = 2'd1; exp_pa = 0; exp_n = 1; end
    else if (!e[31]) begin exp_f = 2'd2; exp_pa = 0; exp_n = 2; end
    else             begin exp_f = 2'd0; exp_pa = {e[7:0], va[5:0]}; exp_n = 2; end
    @(negedge clk);
    nreads = 0;
    req_valid = 1; req_vaddr = va;
    if (mode == 1) begin base_we = 1; base_wdata = nb; end
    @(negedge clk);
    req_valid = 0; base_we = 0;
    if (mode == 1) base_m = nb;
    chk(req_ready == 0, "R7 busy after accept", req_ready, 0);
    if (mode == 2) begin
      base_we = 1; base_wdata = nb;
      @(negedge clk);
      base_we = 0; base_m = nb;
    end
    guard = 0;
    while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
    chk(rsp_valid == 1, "R7 response arrives", rsp_valid, 1);
    chk(rd_log[0] == pa, mode != 0 ? "R8 first read uses old base" : "R2 directory read address", rd_log[0], pa);
    chk(nreads == exp_n, exp_f == 1 ? "R3 single read on directory fault" : "R5 two reads", nreads, exp_n);
    if (exp_n == 2) chk(rd_log[1] == pt, "R4 table read address", rd_log[1], pt);
    chk(rsp_fault == exp_f, exp_f == 0 ? "R6 fault code" : (exp_f == 1 ? "R3 fault code" : "R5 fault code"), rsp_fault, exp_f);
    chk(rsp_paddr == exp_pa, exp_f == 0 ? "R6 physical address" : "R5 address zero on fault", rsp_paddr, exp_pa);
    @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R7 one-cycle response", {rsp_valid, req_ready}, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = {($urandom_range(0, 4) != 0), 31'($urandom())};
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_rd_req == 0, "R1 reset outputs",
        {req_ready, rsp_valid, mem_rd_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    set_path(14'd0, 14'h2A5, 1, 1);
    do_walk(14'h2A5, 0, 0);
    chk(rd_log[0] == 14'h000 + 14'h0, "R1 base resets to zero", rd_log[0], 0);
    set_path(base_m, 14'h3C11, 0, 1);
    do_walk(14'h3C11, 0, 0);
    set_path(base_m, 14'h1234, 1, 0);
    do_walk(14'h1234, 0, 0);
    set_path(base_m, 14'h0FFF, 1, 1);
    do_walk(14'h0FFF, 1, 14'h3FF0);
    set_path(14'h3FF0, 14'h3C3F, 1, 1);
    do_walk(14'h3C3F, 0, 0);
    chk(rd_log[0] == 14'h002C, "R2 base plus index wraps", rd_log[0], 14'h002C);
    set_path(base_m, 14'h2000, 1, 1);
    do_walk(14'h2000, 2, 14'h0800);
    set_path(14'h0800, 14'h0040, 1, 1);
    do_walk(14'h0040, 0, 0);
    @(negedge clk);
    stray = 1;
    @(negedge clk);
    stray = 0;
    chk(rsp_valid == 0 && req_ready == 1 && mem_rd_req == 0, "R9 stray read-valid ignored",
        {rsp_valid, req_ready, mem_rd_req}, 3'b010);
    set_path(base_m, 14'h1555, 1, 1);
    do_walk(14'h1555, 0, 0);
    for (int n = 0; n < 60; n++) begin
      logic [13:0] va = 14'($urandom());
      int          md = $urandom_range(0, 2);
      logic [13:0] nb = {12'($urandom()), 2'b00};
      if ($urandom_range(0, 1) == 1) set_path(base_m, va, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
      do_walk(va, md, nb);
    end
    summary();
  end
endmodule